// File: doc/BRIEF.md
# System Sleep State Controller

This block follows the global power state of a processor-based system and picks the next state from trigger events. Five states are tracked: full operation, processor idle, suspend-to-memory, a single merged suspend-to-disk/soft-off state, and mechanical-off. The events that drive it are a processor idle request, a sleep-enable strobe with a 3-bit sleep-type code, a power-button-override pulse, a wake event and a main-power-good level. Every transition takes one clock.

From the current state the block produces three rail enables: core, memory self-refresh and the resume well. It also drives a one-cycle flag that tells the boot logic a full boot is needed. While power is good, a held register records the state most recently entered. When power comes back after a mechanical-off, that record decides the recovery state.

Top module: `sslp_ctrl`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the block enters full-on. The state code is 0, core and resume enables are 1, self-refresh is 0, and the full-boot flag is 0.
- R2: In full-on, an idle request with no higher-priority event moves the state to idle (code 1) at the next edge. In idle, a wake event moves the state back to full-on within one cycle.
- R3: In full-on, sleep-enable with sleep-type 3'b011 moves the state to suspend-to-memory (code 2). Sleep-type 3'b100 or 3'b101 moves it to soft-off (code 3). Any other sleep-type with sleep-enable set keeps full-on and blocks an idle request in the same cycle.
- R4: A power-button-override in full-on, idle or suspend-to-memory moves the state to soft-off. It takes priority over sleep-enable, idle request and wake.
- R5: Power-good sampled low in any state other than mechanical-off moves the state to mechanical-off (code 4). This takes priority over every other event.
- R6: A wake event in suspend-to-memory or soft-off returns the state to full-on. In mechanical-off, wake and all other events except power-good are ignored. In suspend-to-memory, an idle request is ignored.
- R7: In mechanical-off, power-good sampled high moves the state to soft-off if the state held before the loss was suspend-to-memory or soft-off. Otherwise it moves the state to full-on. The held state is recorded only at edges where power-good is high.
- R8: The rail enables {core, self-refresh, resume} are 101 in full-on and idle, 011 in suspend-to-memory, 001 in soft-off and 000 in mechanical-off. They change at the same edge as the state.
- R9: The full-boot flag is high for exactly the first full-on cycle that follows soft-off, and low at all other times.
- R10: Under arbitrary event mixes, the state code and all outputs follow the priority order power-fail, override, sleep-enable, idle/wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_req | input | 1 | Processor idle request |
| sleep_en | input | 1 | Sleep-enable strobe |
| sleep_type | input | 3 | Requested sleep type |
| pb_override | input | 1 | Power-button-override pulse |
| wake | input | 1 | Wake event |
| pwr_good | input | 1 | Main power good |
| state_code | output | 3 | Current state: 0 on, 1 idle, 2 suspend-to-memory, 3 soft-off, 4 mechanical-off |
| core_en | output | 1 | Core rail enable |
| mem_sr_en | output | 1 | Memory self-refresh enable |
| resume_en | output | 1 | Resume-well enable |
| full_boot | output | 1 | Full boot required pulse |

## Verification
Because the state code is a port, a wrong next-state decision is visible one edge after the triggering input. A wrong priority shows as the wrong code at that same edge. A corrupt held pre-loss state stays hidden until power returns, and then appears as full-on where soft-off was expected, or the reverse. For that reason the bench drops power from every state. A rail or full-boot error appears in the same cycle as the state it belongs to.

// File: rtl/sslp_pkg.sv
package sslp_pkg;

    parameter int SLP_TYPE_W = 3;
    parameter int STATE_W    = 3;

    localparam logic [SLP_TYPE_W-1:0] SLPT_STR    = SLP_TYPE_W'(3);
    localparam logic [SLP_TYPE_W-1:0] SLPT_SOFT_A = SLP_TYPE_W'(4);
    localparam logic [SLP_TYPE_W-1:0] SLPT_SOFT_B = SLP_TYPE_W'(5);

    typedef enum logic [STATE_W-1:0] {
        ST_ON   = 3'd0,
        ST_IDLE = 3'd1,
        ST_STR  = 3'd2,
        ST_SOFT = 3'd3,
        ST_MOFF = 3'd4
    } sys_state_e;

    typedef enum logic [1:0] {
        SLP_NONE = 2'd0,
        SLP_STR  = 2'd1,
        SLP_SOFT = 2'd2,
        SLP_BAD  = 2'd3
    } slp_req_e;

    typedef struct packed {
        logic     pgood;
        logic     pbo;
        slp_req_e slp;
        logic     idle;
        logic     wake;
    } trig_s;

    typedef struct packed {
        logic core;
        logic mem_sr;
        logic resume;
    } rails_s;

    function automatic slp_req_e decode_slp(input logic en,
                                            input logic [SLP_TYPE_W-1:0] t);
        slp_req_e r;
        if (!en)
            r = SLP_NONE;
        else if (t == SLPT_STR)
            r = SLP_STR;
        else if (t == SLPT_SOFT_A || t == SLPT_SOFT_B)
            r = SLP_SOFT;
        else
            r = SLP_BAD;
        return r;
    endfunction

    function automatic rails_s rails_of(input sys_state_e s);
        rails_s r;
        unique case (s)
            ST_ON, ST_IDLE: r = '{core: 1'b1, mem_sr: 1'b0, resume: 1'b1};
            ST_STR:         r = '{core: 1'b0, mem_sr: 1'b1, resume: 1'b1};
            ST_SOFT:        r = '{core: 1'b0, mem_sr: 1'b0, resume: 1'b1};
            default:        r = '{core: 1'b0, mem_sr: 1'b0, resume: 1'b0};
        endcase
        return r;
    endfunction

    function automatic logic recovers_asleep(input sys_state_e s);
        return (s == ST_STR) || (s == ST_SOFT);
    endfunction

endpackage

// File: rtl/sslp_trigger.sv
module sslp_trigger
    import sslp_pkg::*;
(
    input  logic                  idle_req,
    input  logic                  sleep_en,
    input  logic [SLP_TYPE_W-1:0] sleep_type,
    input  logic                  pb_override,
    input  logic                  wake,
    input  logic                  pwr_good,
    output trig_s                 trig
);
    always_comb begin
        trig.pgood = pwr_good;
        trig.pbo   = pb_override;
        trig.slp   = decode_slp(sleep_en, sleep_type);
        trig.idle  = idle_req;
        trig.wake  = wake;
    end
endmodule

// File: rtl/sslp_next.sv
module sslp_next
    import sslp_pkg::*;
(
    input  sys_state_e cur,
    input  sys_state_e held,
    input  trig_s      trig,
    output sys_state_e nxt,
    output logic       boot_nxt
);
    always_comb begin
        nxt = cur;
        if (cur == ST_MOFF) begin
            if (trig.pgood)
                nxt = recovers_asleep(held) ? ST_SOFT : ST_ON;
        end else if (!trig.pgood) begin
            nxt = ST_MOFF;
        end else begin
            unique case (cur)
                ST_ON: begin
                    if (trig.pbo)
                        nxt = ST_SOFT;
                    else if (trig.slp == SLP_STR)
                        nxt = ST_STR;
                    else if (trig.slp == SLP_SOFT)
                        nxt = ST_SOFT;
                    else if (trig.slp == SLP_BAD)
                        nxt = ST_ON;
                    else if (trig.idle)
                        nxt = ST_IDLE;
                end
                ST_IDLE, ST_STR: begin
                    if (trig.pbo)
                        nxt = ST_SOFT;
                    else if (trig.wake)
                        nxt = ST_ON;
                end
                ST_SOFT: begin
                    if (trig.wake)
                        nxt = ST_ON;
                end
                default: nxt = ST_ON;
            endcase
        end
        boot_nxt = (cur == ST_SOFT) && (nxt == ST_ON);
    end
endmodule

// File: rtl/sslp_regs.sv
module sslp_regs
    import sslp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sys_state_e nxt,
    input  logic       boot_nxt,
    input  logic       pgood,
    output sys_state_e cur,
    output sys_state_e held,
    output logic       boot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= ST_ON;
            held <= ST_ON;
            boot <= 1'b0;
        end else begin
            cur  <= nxt;
            boot <= boot_nxt;
            if (pgood && cur != ST_MOFF)
                held <= nxt;
        end
    end
endmodule

// File: rtl/sslp_rails.sv
module sslp_rails
    import sslp_pkg::*;
#(
    parameter bit REG_RAILS = 1'b1
)(
    input  logic       clk,
    input  logic       rst,
    input  sys_state_e cur,
    input  sys_state_e nxt,
    output rails_s     rails
);
    generate
        if (REG_RAILS) begin : g_reg
            rails_s rails_q;
            always_ff @(posedge clk) begin
                if (rst)
                    rails_q <= rails_of(ST_ON);
                else
                    rails_q <= rails_of(nxt);
            end
            assign rails = rails_q;
        end else begin : g_comb
            sys_state_e unused_nxt;
            logic       unused_ck;
            assign unused_nxt = nxt;
            assign unused_ck  = clk ^ rst;
            assign rails      = rails_of(cur);
        end
    endgenerate
endmodule

// File: rtl/sslp_ctrl.sv
module sslp_ctrl
    import sslp_pkg::*;
#(
    parameter bit REG_RAILS = 1'b1
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  idle_req,
    input  logic                  sleep_en,
    input  logic [SLP_TYPE_W-1:0] sleep_type,
    input  logic                  pb_override,
    input  logic                  wake,
    input  logic                  pwr_good,
    output logic [STATE_W-1:0]    state_code,
    output logic                  core_en,
    output logic                  mem_sr_en,
    output logic                  resume_en,
    output logic                  full_boot
);
    trig_s      trig;
    sys_state_e cur;
    sys_state_e held;
    sys_state_e nxt;
    logic       boot_nxt;
    rails_s     rails;

    sslp_trigger u_trig (
        .idle_req    (idle_req),
        .sleep_en    (sleep_en),
        .sleep_type  (sleep_type),
        .pb_override (pb_override),
        .wake        (wake),
        .pwr_good    (pwr_good),
        .trig        (trig)
    );

    sslp_next u_next (
        .cur      (cur),
        .held     (held),
        .trig     (trig),
        .nxt      (nxt),
        .boot_nxt (boot_nxt)
    );

    sslp_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .nxt      (nxt),
        .boot_nxt (boot_nxt),
        .pgood    (trig.pgood),
        .cur      (cur),
        .held     (held),
        .boot     (full_boot)
    );

    sslp_rails #(.REG_RAILS(REG_RAILS)) u_rails (
        .clk   (clk),
        .rst   (rst),
        .cur   (cur),
        .nxt   (nxt),
        .rails (rails)
    );

    assign state_code = cur;
    assign core_en    = rails.core;
    assign mem_sr_en  = rails.mem_sr;
    assign resume_en  = rails.resume;
endmodule

// File: rtl/sslp_ctrl_checker.sv
module sslp_ctrl_checker
    import sslp_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  idle_req,
    input logic                  sleep_en,
    input logic [SLP_TYPE_W-1:0] sleep_type,
    input logic                  pb_override,
    input logic                  wake,
    input logic                  pwr_good,
    input logic [STATE_W-1:0]    state_code,
    input logic                  core_en,
    input logic                  mem_sr_en,
    input logic                  resume_en,
    input logic                  full_boot
);
    logic in_moff;
    logic powered_low;
    assign in_moff     = (state_code == ST_MOFF);
    assign powered_low = (state_code == ST_ON) || (state_code == ST_IDLE) ||
                         (state_code == ST_STR);

    assert_pfail_R5: assert property (@(posedge clk) disable iff (rst)
        (!pwr_good && !in_moff) |=> (state_code == ST_MOFF));

    assert_moff_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (in_moff && !pwr_good) |=> (state_code == ST_MOFF));

    assert_override_R4: assert property (@(posedge clk) disable iff (rst)
        (pwr_good && pb_override && powered_low) |=> (state_code == ST_SOFT));

    assert_idle_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_ON && pwr_good && !pb_override && !sleep_en && idle_req)
        |=> (state_code == ST_IDLE));

    assert_str_rails_R8: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_STR) |-> (!core_en && mem_sr_en && resume_en));

    assert_moff_rails_R8: assert property (@(posedge clk) disable iff (rst)
        in_moff |-> (!core_en && !mem_sr_en && !resume_en));

    assert_boot_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        full_boot |-> (state_code == ST_ON && $past(state_code) == ST_SOFT));

    assert_code_legal_R10: assert property (@(posedge clk) disable iff (rst)
        state_code <= ST_MOFF);
endmodule

bind sslp_ctrl sslp_ctrl_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .idle_req    (idle_req),
    .sleep_en    (sleep_en),
    .sleep_type  (sleep_type),
    .pb_override (pb_override),
    .wake        (wake),
    .pwr_good    (pwr_good),
    .state_code  (state_code),
    .core_en     (core_en),
    .mem_sr_en   (mem_sr_en),
    .resume_en   (resume_en),
    .full_boot   (full_boot)
);

// File: tb/sslp_ctrl_bench.sv
module sslp_ctrl_bench;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       idle_req, sleep_en, pb_override, wake, pwr_good;
    logic [2:0] sleep_type;
    logic [2:0] state_code;
    logic       core_en, mem_sr_en, resume_en, full_boot;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_state = 0;
    int m_prior = 0;
    int m_boot  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sslp_ctrl u_sslp_ctrl (
        .clk(clk), .rst(rst), .idle_req(idle_req), .sleep_en(sleep_en),
        .sleep_type(sleep_type), .pb_override(pb_override), .wake(wake),
        .pwr_good(pwr_good), .state_code(state_code), .core_en(core_en),
        .mem_sr_en(mem_sr_en), .resume_en(resume_en), .full_boot(full_boot)
    );

    // Reference behaviour: 0 on, 1 idle, 2 suspend-to-memory, 3 soft-off, 4 mech-off
    task automatic model_edge();
        int n;
        if (rst) begin
            m_state = 0; m_prior = 0; m_boot = 0;
            return;
        end
        n = m_state;
        if (m_state == 4) begin
            if (pwr_good) n = (m_prior == 2 || m_prior == 3) ? 3 : 0;
        end else if (!pwr_good) begin
            n = 4;
        end else if (pb_override && m_state != 3) begin
            n = 3;
        end else if (m_state == 0) begin
            if (sleep_en) begin
                if (sleep_type == 3'b011) n = 2;
                else if (sleep_type == 3'b100 || sleep_type == 3'b101) n = 3;
            end else if (idle_req) n = 1;
        end else if (wake) begin
            n = 0;
        end
        m_boot = (m_state == 3 && n == 0) ? 1 : 0;
        if (pwr_good && m_state != 4) m_prior = n;
        m_state = n;
    endtask

    task automatic compare(input string tag);
        logic [2:0] exp_rails;
        case (m_state)
            0, 1:    exp_rails = 3'b101;
            2:       exp_rails = 3'b011;
            3:       exp_rails = 3'b001;
            default: exp_rails = 3'b000;
        endcase
        checks++;
        if (state_code !== 3'(m_state) || {core_en, mem_sr_en, resume_en} !== exp_rails ||
            full_boot !== 1'(m_boot)) begin
            fails++;
            $display("FAIL %s: state=%0d rails=%b boot=%b, expected state=%0d rails=%b boot=%0d",
                     tag, state_code, {core_en, mem_sr_en, resume_en}, full_boot,
                     m_state, exp_rails, m_boot);
        end
    endtask

    task automatic step(input logic i_idle, input logic i_slp, input logic [2:0] i_typ,
                        input logic i_pbo, input logic i_wake, input logic i_pg,
                        input string tag);
        idle_req = i_idle; sleep_en = i_slp; sleep_type = i_typ;
        pb_override = i_pbo; wake = i_wake; pwr_good = i_pg;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        step(0, 0, 3'b000, 0, 0, 1, "R1");
        step(1, 1, 3'b011, 1, 1, 1, "R1 R8");
        rst = 1'b0;

        step(1, 0, 3'b000, 0, 0, 1, "R2");
        step(0, 0, 3'b000, 0, 0, 1, "R2");
        step(0, 0, 3'b000, 0, 1, 1, "R2");

        step(0, 1, 3'b011, 0, 0, 1, "R3 R8");
        step(1, 0, 3'b000, 0, 0, 1, "R6");
        step(0, 0, 3'b000, 0, 1, 1, "R6");

        foreach (sleep_type[i]) begin end
        for (int t = 0; t < 8; t++) begin
            if (t == 3 || t == 4 || t == 5) continue;
            step(1, 1, 3'(t), 0, 0, 1, "R3");
        end

        step(0, 1, 3'b100, 0, 0, 1, "R3 R8");
        step(0, 0, 3'b000, 0, 1, 1, "R9");
        step(0, 0, 3'b000, 0, 0, 1, "R9");
        step(0, 1, 3'b101, 0, 0, 1, "R3");
        step(0, 0, 3'b000, 1, 0, 1, "R4");
        step(0, 0, 3'b000, 0, 1, 1, "R9");

        step(1, 1, 3'b011, 1, 0, 1, "R4");
        step(0, 0, 3'b000, 0, 1, 1, "R6");
        step(1, 0, 3'b000, 0, 0, 1, "R2");
        step(0, 0, 3'b000, 1, 1, 1, "R4");
        step(0, 0, 3'b000, 0, 1, 1, "R6");
        step(0, 1, 3'b011, 0, 0, 1, "R3");
        step(0, 0, 3'b000, 1, 1, 1, "R4");
        step(0, 0, 3'b000, 0, 1, 1, "R9");

        step(1, 1, 3'b011, 1, 0, 0, "R5 R8");
        step(0, 0, 3'b000, 0, 1, 0, "R6");
        step(0, 0, 3'b000, 0, 0, 1, "R7");
        step(1, 0, 3'b000, 0, 0, 1, "R2");
        step(0, 0, 3'b000, 0, 0, 0, "R5");
        step(0, 0, 3'b000, 0, 0, 1, "R7");
        step(0, 1, 3'b011, 0, 0, 1, "R3");
        step(0, 0, 3'b000, 0, 1, 0, "R5");
        step(0, 0, 3'b000, 0, 1, 1, "R7");
        step(0, 0, 3'b000, 0, 1, 1, "R9");
        step(0, 1, 3'b100, 0, 0, 1, "R3");
        step(0, 0, 3'b000, 0, 0, 0, "R5");
        step(0, 0, 3'b000, 0, 0, 1, "R7");
        step(0, 0, 3'b000, 0, 1, 1, "R9");

        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom;
            step(r[0], r[1] & r[2], r[5:3], r[6] & r[7] & r[8], r[9],
                 (r[12:10] != 3'b000), "R10");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule